// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Integer Pipeline

This block is the exception control for an in-order integer pipeline with fetch, decode, execute, memory and writeback stages. The stages report fault strobes and the block does not act on them when they arrive. Each fault sets a bit in a status word that moves down the pipeline with its instruction. An instruction whose status word has any bit set loses its register write and its memory write. The block examines the status word only as the instruction leaves the memory stage, so faults are taken strictly in program order.

When an instruction with a posted fault leaves the memory stage, the block takes the trap. It redirects fetch to a fixed trap vector and clears the faulting instruction and every younger one in flight. Older instructions are already past the memory stage and retire normally. The block records the cause of the earliest stage that faulted and keeps the restart addresses. With a branch delay of length D it keeps D+1 addresses. A return-from-exception strobe replays those addresses into fetch, and sequential fetch then continues. The pipeline advances one stage every cycle. A cycle with no fetched instruction puts a bubble into the pipeline.

Top module: `precise_trap_ctrl`

## Requirements
- R1: During and right after synchronous reset, the fetch address is RESET_PC and the pipeline holds no valid instruction: trap_o, wb_valid_o, rf_we_o and mem_we_o are low, and cause_o is 0.
- R2: When there is no redirect, the fetch address advances by 4 on every cycle in which fetch_valid_i is high.
- R3: An instruction whose status word has any bit set never drives mem_we_o, including a store that faults in the memory stage in that same cycle. It never drives rf_we_o. rf_we_o is high only together with wb_valid_o.
- R4: Faults are taken only as an instruction leaves the memory stage. All faults of instruction i are taken before any fault of instruction i+1, even when i+1 raised its fault in an earlier cycle.
- R5: Status bit positions are: 0 fetch page fault, 1 fetch misaligned, 2 fetch protection, 3 illegal opcode, 4 arithmetic, 5 data page fault, 6 data misaligned, 7 data protection. cause_o is the index of the lowest set bit plus 1, so the earliest stage wins and the codes run 1 to 8. The value 0 means no trap has been taken since reset.
- R6: In the cycle after the faulting instruction leaves the memory stage, trap_o is high for exactly one cycle and fetch_pc_o equals TRAP_VEC.
- R7: The faulting instruction and all younger ones never reach writeback. All older instructions retire in program order.
- R8: saved_pc_o holds BR_DELAY+1 addresses. Slot 0 (the low bits) is the faulting instruction and the following slots are its successors in program order. The value holds until the next trap.
- R9: One cycle after rfe_i, fetch_pc_o equals saved slot 0. The following cycles present the later slots in turn, and then fetch proceeds sequentially from the last slot.
- R10: A fault strobe that arrives while its stage holds a bubble has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction is fetched at fetch_pc_o this cycle |
| if_exc_i | input | 3 | Fetch faults: page, misaligned, protection |
| id_ill_i | input | 1 | Decode: illegal opcode |
| ex_arith_i | input | 1 | Execute: arithmetic fault |
| mem_exc_i | input | 3 | Memory faults: page, misaligned, protection |
| rf_we_i | input | 1 | Register write request of the instruction in decode |
| mem_we_i | input | 1 | Store request of the instruction in decode |
| rfe_i | input | 1 | Return from exception |
| fetch_pc_o | output | PC_W | Current fetch address |
| mem_we_o | output | 1 | Gated store enable for the instruction in the memory stage |
| rf_we_o | output | 1 | Gated register write enable in writeback |
| wb_valid_o | output | 1 | An instruction retires this cycle |
| wb_pc_o | output | PC_W | Address of the retiring instruction |
| trap_o | output | 1 | One-cycle trap indication |
| cause_o | output | 4 | Encoded cause of the last trap |
| saved_pc_o | output | (BR_DELAY+1)*PC_W | Restart addresses, slot 0 in the low bits |

## Verification
The assertions rely on a few assumptions about the inputs. A stage strobe describes whatever that stage holds in the current cycle. rfe_i is never raised in the same cycle as a trap or during reset. The pipeline never stalls, so one cycle always means one stage. The bench starts every case from reset, so it knows which address sits in each stage in each cycle. It derives every strobe from that schedule and stops driving faults once the trap is taken, so it never puts a fault on a handler instruction. The only strobes it sends to bubbles are the deliberate ones in the first cycles after reset.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  // status word layout: lower index = earlier stage = higher priority
  localparam int ST_W     = 8;
  localparam int IF_BASE  = 0;  // 3 fetch bits
  localparam int IF_N     = 3;
  localparam int ID_BIT   = 3;
  localparam int EX_BIT   = 4;
  localparam int MEM_BASE = 5;  // 3 memory bits
  localparam int MEM_N    = 3;
  localparam int CAUSE_W  = 4;
endpackage

// File: rtl/ptc_prio.sv
`timescale 1ns/1ps
module ptc_prio
  import ptc_pkg::*;
(
  input  logic [ST_W-1:0]    st,
  output logic [CAUSE_W-1:0] cause,
  output logic               any
);
  always_comb begin
    cause = '0;
    for (int i = ST_W - 1; i >= 0; i--) begin
      if (st[i]) cause = CAUSE_W'(i + 1);
    end
    any = |st;
  end
endmodule

// File: rtl/ptc_stage.sv
`timescale 1ns/1ps
module ptc_stage
  import ptc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  logic [ST_W-1:0] in_st,
  input  logic            in_rfw,
  input  logic            in_mw,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic [ST_W-1:0] q_st,
  output logic            q_rfw,
  output logic            q_mw
);
  // squash zeroes the whole latch so a killed slot can change no state
  always_ff @(posedge clk) begin
    if (rst || kill) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_st    <= '0;
      q_rfw   <= 1'b0;
      q_mw    <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_pc    <= in_pc;
      q_st    <= in_st;
      q_rfw   <= in_rfw;
      q_mw    <= in_mw;
    end
  end
endmodule

// File: rtl/ptc_fetch.sv
`timescale 1ns/1ps
module ptc_fetch #(
  parameter int          PC_W     = 32,
  parameter int          NSAVE    = 2,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [31:0] TRAP_VEC = 32'h100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  take,
  input  logic                  rfe,
  input  logic [NSAVE*PC_W-1:0] cap,
  output logic [PC_W-1:0]       pc,
  output logic [NSAVE*PC_W-1:0] saved
);
  localparam int RC_W = $clog2(NSAVE + 1);

  logic [PC_W-1:0] sv [NSAVE];
  logic [RC_W-1:0] rcnt;
  logic [PC_W-1:0] slot;

  always_comb begin
    slot = sv[0];
    for (int k = 0; k < NSAVE; k++) begin
      if (rcnt == RC_W'(k)) slot = sv[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= PC_W'(RESET_PC);
      rcnt <= '0;
      for (int k = 0; k < NSAVE; k++) sv[k] <= '0;
    end else if (take) begin
      pc   <= PC_W'(TRAP_VEC);
      rcnt <= '0;
      for (int k = 0; k < NSAVE; k++) sv[k] <= cap[k*PC_W +: PC_W];
    end else if (rfe) begin
      pc   <= sv[0];
      rcnt <= (NSAVE > 1) ? RC_W'(1) : '0;
    end else if (adv) begin
      if (rcnt != '0) begin
        pc   <= slot;
        rcnt <= (rcnt == RC_W'(NSAVE - 1)) ? '0 : rcnt + RC_W'(1);
      end else begin
        pc <= pc + PC_W'(4);
      end
    end
  end

  for (genvar g = 0; g < NSAVE; g++) begin : g_out
    assign saved[g*PC_W +: PC_W] = sv[g];
  end
endmodule

// File: rtl/precise_trap_ctrl.sv
`timescale 1ns/1ps
module precise_trap_ctrl
  import ptc_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          BR_DELAY = 1,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [31:0] TRAP_VEC = 32'h100
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fetch_valid_i,
  input  logic [2:0]                   if_exc_i,
  input  logic                         id_ill_i,
  input  logic                         ex_arith_i,
  input  logic [2:0]                   mem_exc_i,
  input  logic                         rf_we_i,
  input  logic                         mem_we_i,
  input  logic                         rfe_i,
  output logic [PC_W-1:0]              fetch_pc_o,
  output logic                         mem_we_o,
  output logic                         rf_we_o,
  output logic                         wb_valid_o,
  output logic [PC_W-1:0]              wb_pc_o,
  output logic                         trap_o,
  output logic [3:0]                   cause_o,
  output logic [(BR_DELAY+1)*PC_W-1:0] saved_pc_o
);
  // restart slots are taken from in-flight stages: M, E, D, F (max delay 3)
  localparam int NSAVE = BR_DELAY + 1;

  logic            d_v, e_v, m_v;
  logic [PC_W-1:0] d_pc, e_pc, m_pc;
  logic [ST_W-1:0] d_st, e_st, m_st;
  logic            d_rfw, e_rfw, m_rfw;
  logic            d_mw, e_mw, m_mw;
  logic            take, m_bad;
  logic [ST_W-1:0] d_in_st, e_in_st, m_in_st, m_eff;
  logic [CAUSE_W-1:0] m_cause;
  logic [NSAVE*PC_W-1:0] cap;
  logic            f_keep;
  logic            w_v, w_rfw;
  logic [PC_W-1:0] w_pc;
  logic            trap_q;
  logic [CAUSE_W-1:0] cause_q;

  // fetch slot is dropped on a trap or a return redirect
  assign f_keep  = fetch_valid_i && !take && !rfe_i;
  assign d_in_st = ST_W'({IF_N{f_keep}} & if_exc_i) << IF_BASE;
  assign e_in_st = d_st | (ST_W'(id_ill_i && d_v) << ID_BIT);
  assign m_in_st = e_st | (ST_W'(ex_arith_i && e_v) << EX_BIT);
  assign m_eff   = m_st | (ST_W'({MEM_N{m_v}} & mem_exc_i) << MEM_BASE);

  ptc_stage #(.PC_W(PC_W)) u_d (
    .clk(clk), .rst(rst), .kill(take),
    .in_valid(f_keep), .in_pc(fetch_pc_o), .in_st(d_in_st),
    .in_rfw(1'b0), .in_mw(1'b0),
    .q_valid(d_v), .q_pc(d_pc), .q_st(d_st), .q_rfw(d_rfw), .q_mw(d_mw)
  );

  // write requests join the instruction once decode has produced them
  ptc_stage #(.PC_W(PC_W)) u_e (
    .clk(clk), .rst(rst), .kill(take),
    .in_valid(d_v), .in_pc(d_pc), .in_st(e_in_st),
    .in_rfw((rf_we_i && d_v) || d_rfw), .in_mw((mem_we_i && d_v) || d_mw),
    .q_valid(e_v), .q_pc(e_pc), .q_st(e_st), .q_rfw(e_rfw), .q_mw(e_mw)
  );

  ptc_stage #(.PC_W(PC_W)) u_m (
    .clk(clk), .rst(rst), .kill(take),
    .in_valid(e_v), .in_pc(e_pc), .in_st(m_in_st),
    .in_rfw(e_rfw), .in_mw(e_mw),
    .q_valid(m_v), .q_pc(m_pc), .q_st(m_st), .q_rfw(m_rfw), .q_mw(m_mw)
  );

  ptc_prio u_prio (.st(m_eff), .cause(m_cause), .any(m_bad));

  // the single decision point: status word leaving the memory stage
  assign take     = m_v && m_bad;
  assign mem_we_o = m_v && m_mw && !m_bad;

  for (genvar g = 0; g < NSAVE; g++) begin : g_cap
    if (g == 0) begin : g_m
      assign cap[g*PC_W +: PC_W] = m_pc;
    end else if (g == 1) begin : g_e
      assign cap[g*PC_W +: PC_W] = e_pc;
    end else if (g == 2) begin : g_d
      assign cap[g*PC_W +: PC_W] = d_pc;
    end else begin : g_f
      assign cap[g*PC_W +: PC_W] = fetch_pc_o;
    end
  end

  ptc_fetch #(
    .PC_W(PC_W), .NSAVE(NSAVE), .RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC)
  ) u_fetch (
    .clk(clk), .rst(rst), .adv(fetch_valid_i), .take(take), .rfe(rfe_i),
    .cap(cap), .pc(fetch_pc_o), .saved(saved_pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_v     <= 1'b0;
      w_pc    <= '0;
      w_rfw   <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      w_v    <= m_v && !take;
      w_pc   <= m_pc;
      w_rfw  <= m_v && m_rfw && !m_bad;
      trap_q <= take;
      if (take) cause_q <= m_cause;
    end
  end

  assign wb_valid_o = w_v;
  assign wb_pc_o    = w_pc;
  assign rf_we_o    = w_v && w_rfw;
  assign trap_o     = trap_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/ptc_chk.sv
`timescale 1ns/1ps
module ptc_chk #(
  parameter int          PC_W     = 32,
  parameter int          NSAVE    = 2,
  parameter logic [31:0] TRAP_VEC = 32'h100
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rfe_i,
  input logic [2:0]            mem_exc_i,
  input logic [PC_W-1:0]       fetch_pc_o,
  input logic                  mem_we_o,
  input logic                  rf_we_o,
  input logic                  wb_valid_o,
  input logic                  trap_o,
  input logic [3:0]            cause_o,
  input logic [NSAVE*PC_W-1:0] saved_pc_o
);
  a_r3_store_blocked: assert property (@(posedge clk) disable iff (rst)
    (|mem_exc_i) |-> !mem_we_o);
  a_r3_rf_needs_retire: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> wb_valid_o);
  a_r5_cause_range: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (cause_o != 4'd0 && cause_o <= 4'd8));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);
  a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> fetch_pc_o == PC_W'(TRAP_VEC));
  a_r7_no_retire_on_trap: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !wb_valid_o);
  a_r9_replay_start: assert property (@(posedge clk) disable iff (rst)
    ($past(rfe_i) && !$past(rst) && !trap_o) |-> fetch_pc_o == saved_pc_o[PC_W-1:0]);
endmodule

bind precise_trap_ctrl ptc_chk #(
  .PC_W(PC_W), .NSAVE(BR_DELAY + 1), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk(clk), .rst(rst), .rfe_i(rfe_i), .mem_exc_i(mem_exc_i),
  .fetch_pc_o(fetch_pc_o), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o),
  .wb_valid_o(wb_valid_o), .trap_o(trap_o), .cause_o(cause_o),
  .saved_pc_o(saved_pc_o)
);

// File: tb/precise_trap_ctrl_test.sv
`timescale 1ns/1ps
module precise_trap_ctrl_test;
  localparam int PC_W = 32;
  localparam int BRD  = 1;
  localparam logic [31:0] TVEC = 32'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid_i = 1'b0;
  logic [2:0] if_exc_i = '0;
  logic id_ill_i = 1'b0, ex_arith_i = 1'b0;
  logic [2:0] mem_exc_i = '0;
  logic rf_we_i = 1'b0, mem_we_i = 1'b0, rfe_i = 1'b0;
  logic [PC_W-1:0] fetch_pc_o, wb_pc_o;
  logic mem_we_o, rf_we_o, wb_valid_o, trap_o;
  logic [3:0] cause_o;
  logic [(BRD+1)*PC_W-1:0] saved_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  precise_trap_ctrl #(.PC_W(PC_W), .BR_DELAY(BRD), .RESET_PC(32'h0), .TRAP_VEC(TVEC)) uut (
    .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i), .if_exc_i(if_exc_i),
    .id_ill_i(id_ill_i), .ex_arith_i(ex_arith_i), .mem_exc_i(mem_exc_i),
    .rf_we_i(rf_we_i), .mem_we_i(mem_we_i), .rfe_i(rfe_i),
    .fetch_pc_o(fetch_pc_o), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o),
    .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o), .trap_o(trap_o),
    .cause_o(cause_o), .saved_pc_o(saved_pc_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int low_cause(input int m);
    for (int i = 0; i < 8; i++) if (m[i]) return i + 1;
    return 0;
  endfunction

  // status mask of instruction k in this case
  function automatic int mk(input int k, input int idx, input int ma, input int mb);
    if (k == idx) return ma;
    if (k == idx + 1) return mb;
    return 0;
  endfunction

  task automatic run_case(input int ma, input int mb, input int idx, input bit chk_reset);
    int tr, tm, tend, nret, nexp, cmask;
    bit has;
    has = (ma != 0) || (mb != 0);
    tr  = (ma != 0) ? idx : idx + 1;
    tm  = has ? tr + 3 : 100000;
    tend = has ? tm + 6 : 15;
    cmask = (ma != 0) ? ma : mb;
    nexp = has ? tr : 12;
    nret = 0;
    @(negedge clk);
    rst = 1'b1;
    fetch_valid_i = 1'b0; if_exc_i = '0; id_ill_i = 0; ex_arith_i = 0;
    mem_exc_i = '0; rf_we_i = 0; mem_we_i = 0; rfe_i = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t <= tend; t++) begin
      fetch_valid_i = 1'b1; rf_we_i = 1'b1; mem_we_i = 1'b1;
      rfe_i = (t == tm + 3);
      if (t <= tm) begin
        // deliberate strobes into bubbles after reset (R10)
        if_exc_i   = 3'(mk(t, idx, ma, mb));
        id_ill_i   = (t == 0) ? 1'b1 : mk(t - 1, idx, ma, mb) >> 3 & 1;
        ex_arith_i = (t <= 1) ? 1'b1 : mk(t - 2, idx, ma, mb) >> 4 & 1;
        mem_exc_i  = (t <= 2) ? 3'b111 : 3'(mk(t - 3, idx, ma, mb) >> 5);
      end else begin
        if_exc_i = '0; id_ill_i = 0; ex_arith_i = 0; mem_exc_i = '0;
      end
      #1;
      if (t == 0 && chk_reset) begin
        chk(fetch_pc_o == 0, "R1", "reset fetch pc", fetch_pc_o, 0);
        chk(!trap_o && cause_o == 0, "R1", "reset trap/cause", {trap_o, cause_o}, 0);
        chk(!wb_valid_o && !rf_we_o && !mem_we_o, "R1", "reset valids",
            {wb_valid_o, rf_we_o, mem_we_o}, 0);
      end
      if (t <= tm)
        chk(fetch_pc_o == PC_W'(4 * t), "R2", "sequential fetch", fetch_pc_o, 4 * t);
      chk(rf_we_o == wb_valid_o, "R3", "rf write vs retire", rf_we_o, wb_valid_o);
      if (t < 3)
        chk(!mem_we_o, "R10", "bubble store/fault ignored", mem_we_o, 0);
      else if (t <= tm)
        chk(mem_we_o == (t != tm), "R3", "store gating", mem_we_o, t != tm);
      chk(trap_o == (t == tm + 1), "R6", "trap pulse timing", trap_o, t == tm + 1);
      if (t <= tm + 4 && wb_valid_o) begin
        chk(wb_pc_o == PC_W'(4 * nret), "R7", "retire order", wb_pc_o, 4 * nret);
        nret++;
      end
      if (t == tm + 1) begin
        chk(cause_o == 4'(low_cause(cmask)), (ma != 0 && mb != 0) ? "R4" : "R5",
            "cause", cause_o, low_cause(cmask));
        chk(fetch_pc_o == TVEC, "R6", "trap vector", fetch_pc_o, TVEC);
        chk(saved_pc_o[PC_W-1:0] == PC_W'(4 * tr), "R8", "saved slot 0",
            saved_pc_o[PC_W-1:0], 4 * tr);
        chk(saved_pc_o[2*PC_W-1:PC_W] == PC_W'(4 * tr + 4), "R8", "saved slot 1",
            saved_pc_o[2*PC_W-1:PC_W], 4 * tr + 4);
      end
      if (t == tm + 4)
        chk(fetch_pc_o == PC_W'(4 * tr), "R9", "replay slot 0", fetch_pc_o, 4 * tr);
      if (t == tm + 5)
        chk(fetch_pc_o == PC_W'(4 * tr + 4), "R9", "replay slot 1", fetch_pc_o, 4 * tr + 4);
      if (t == tm + 6)
        chk(fetch_pc_o == PC_W'(4 * tr + 8), "R9", "resume sequential", fetch_pc_o, 4 * tr + 8);
      @(negedge clk);
    end
    chk(nret == nexp, "R7", "retire count", nret, nexp);
  endtask

  initial begin
    for (int ma = 0; ma < 256; ma++) begin
      run_case(ma, 0,    1 + ma % 4, ma == 0);
      run_case(ma, 1,    1 + (ma / 4) % 4, 1'b0);
      run_case(ma, 'h80, 1 + (ma / 16) % 4, 1'b0);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule